// File: doc/BRIEF.md
# Keyed Single-Byte Nonvolatile Write Controller

This block sits on a simple processor register bus and manages byte-sized writes into a small nonvolatile data store. The store is modelled here as a register file. Software loads a target location into an address register and a value into a data latch. It then sets the write-enable bit in the control register, writes a two-byte key to a key register, and sets the start bit. The controller accepts the start only when the key was complete and was the very last thing on the bus. It then waits for the fourth falling edge of an external serial clock. After that edge it erases the byte, programs the new value, and waits for the serial clock to rest low for a discharge interval. Only then does it drop the start bit, which software polls to learn that the write is complete.

A start attempt that fails any of its conditions does nothing to the store and raises a sticky error flag. Every attempt, accepted or not, uses up the key. While a write is in flight, the address, data and control registers ignore bus writes, so the operation keeps stable operands. A read bit in the control register copies the stored byte at the current address into the data latch, so software can read back the store.

Top module: `nvbyte_wr_ctrl`

## Requirements
- R1: Register offsets are 0 address, 1 data latch, 2 control and 3 key. While idle, the address and data registers read back what was written. After reset, the address, data and control registers read 00h and every stored byte is FFh.
- R2: The key is complete only after 55h and then AAh are written to offset 3 as two consecutive bus accesses. Any other bus access (a read or write at any offset, a wrong value, or AAh without a preceding 55h) leaves the key incomplete.
- R3: A control write with bit 1 set starts a write only if three conditions hold: the key is complete, control bit 2 (write enable) was already 1 before this write, and the written bits 7 and 6 are both 0.
- R4: A rejected start attempt sets control bit 3 (error), leaves the store unchanged and leaves bit 1 reading 0. An accepted start clears bit 3. While idle, a control write with bit 3 at 0 clears it.
- R5: Each start attempt consumes the key, whether or not the attempt is accepted. The next attempt needs a fresh 55h/AAh pair.
- R6: After an accepted start, the store is not touched and the operation does not finish until the fourth falling edge of `sclk` that follows the start.
- R7: A write first erases the addressed byte to FFh and then programs the latched value. After completion, the addressed byte holds the value and every other byte is unchanged.
- R8: Control bit 1 reads 1 from the accepted start until the operation has finished, and reads 0 afterwards.
- R9: After programming, completion requires `sclk` to stay low for DISCH_CYC consecutive clock cycles. While `sclk` is high, the operation does not complete.
- R10: While bit 1 reads 1, bus writes to the address, data and control registers are ignored.
- R11: While idle, a control write with bit 0 set and bit 1 clear loads the data latch from the stored byte at the current address. Bit 0 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sclk | input | 1 | External serial clock that times the write; synchronized inside |
| bus_wr | input | 1 | Register write strobe, one cycle per access |
| bus_rd | input | 1 | Register read strobe, one cycle per access |
| bus_ofs | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected offset, combinational |

## Verification
The hardest state to reach is the window after a start is accepted but before the fourth serial-clock fall. Here the block must stay busy and ignore operand writes. A related hard state is the discharge wait while `sclk` is held high. The bench reaches both directly: it gives only three serial-clock pulses and then writes new operands, and it holds `sclk` high for a long stretch after the fourth fall before releasing it. Random flows then mix valid key pairs with each kind of broken key or bad control value. Each result is checked through the read bit against a byte model kept in the bench.

// File: rtl/nvw_pkg.sv
package nvw_pkg;
  typedef enum logic [2:0] {SQ_IDLE, SQ_ARM, SQ_ERASE, SQ_PROG, SQ_DISCH} seq_state_t;
  typedef enum logic [1:0] {UL_NONE, UL_HALF, UL_FULL} key_state_t;

  localparam logic [1:0] OFS_ADDR = 2'd0;
  localparam logic [1:0] OFS_DATA = 2'd1;
  localparam logic [1:0] OFS_CTRL = 2'd2;
  localparam logic [1:0] OFS_KEY  = 2'd3;

  localparam int B_MSEL  = 7;
  localparam int B_CSEL  = 6;
  localparam int B_ERR   = 3;
  localparam int B_WEN   = 2;
  localparam int B_START = 1;
  localparam int B_RD    = 0;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;
endpackage

// File: rtl/nvw_rst_sync.sv
module nvw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/nvw_unlock.sv
module nvw_unlock
  import nvw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_wr,
  input  logic       acc_rd,
  input  logic [1:0] acc_ofs,
  input  logic [7:0] acc_data,
  output logic       armed
);
  key_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (acc_wr || acc_rd) begin
      state_d = UL_NONE;
      if (acc_wr && acc_ofs == OFS_KEY) begin
        if (acc_data == KEY_FIRST)
          state_d = UL_HALF;
        else if (acc_data == KEY_SECOND && state_q == UL_HALF)
          state_d = UL_FULL;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= UL_NONE;
    else        state_q <= state_d;
  end

  assign armed = (state_q == UL_FULL);

  // R2: full key only follows the half key (or is held with no access)
  a_r2_full_after_half: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(state_q) == UL_HALF);
  // R5 / R2: any bus access drops a complete key
  a_r5_access_consumes: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && (acc_wr || acc_rd)) |=> !armed);
endmodule

// File: rtl/nvw_seq.sv
module nvw_seq
  import nvw_pkg::*;
#(
  parameter int EDGES     = 4,
  parameter int ERASE_CYC = 6,
  parameter int PROG_CYC  = 10,
  parameter int DISCH_CYC = 8,
  parameter int SYNC_LEN  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic go,
  output logic busy,
  output logic erase_we,
  output logic prog_we
);
  localparam int M1   = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int M2   = (DISCH_CYC > EDGES) ? DISCH_CYC : EDGES;
  localparam int CMAX = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] L_EDGE  = CW'(EDGES - 1);
  localparam logic [CW-1:0] L_ERASE = CW'(ERASE_CYC - 1);
  localparam logic [CW-1:0] L_PROG  = CW'(PROG_CYC - 1);
  localparam logic [CW-1:0] L_DISCH = CW'(DISCH_CYC - 1);

  logic [SYNC_LEN-1:0] sync_q;
  logic                prev_q;
  logic                sclk_lvl, sclk_fall;
  seq_state_t          state_q, state_d;
  logic [CW-1:0]       cnt_q, cnt_d;

  assign sclk_lvl  = sync_q[SYNC_LEN-1];
  assign sclk_fall = prev_q & ~sclk_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_LEN-2:0], sclk};
      prev_q <= sclk_lvl;
    end
  end

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    erase_we = 1'b0;
    prog_we  = 1'b0;
    case (state_q)
      SQ_IDLE: if (go) begin
        state_d = SQ_ARM;
        cnt_d   = '0;
      end
      SQ_ARM: if (sclk_fall) begin
        if (cnt_q == L_EDGE) begin
          state_d = SQ_ERASE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SQ_ERASE: begin
        erase_we = (cnt_q == '0);
        if (cnt_q == L_ERASE) begin
          state_d = SQ_PROG;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SQ_PROG: begin
        if (cnt_q == L_PROG) begin
          prog_we = 1'b1;
          state_d = SQ_DISCH;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SQ_DISCH: begin
        if (sclk_lvl) begin
          cnt_d = '0;
        end else if (cnt_q == L_DISCH) begin
          state_d = SQ_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = SQ_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy = (state_q != SQ_IDLE);

  // R6: armed sequencer waits for serial-clock falls
  a_r6_arm_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_ARM && !sclk_fall) |=> state_q == SQ_ARM);
  // R7: erase strobe comes straight out of the armed wait
  a_r7_erase_first: assert property (@(posedge clk) disable iff (!rst_n)
    erase_we |-> $past(state_q) == SQ_ARM);
  // R7: programming is followed by discharge, never by idle
  a_r7_prog_then_disch: assert property (@(posedge clk) disable iff (!rst_n)
    prog_we |=> state_q == SQ_DISCH);
  // R9: high serial clock holds the discharge wait
  a_r9_disch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_DISCH && sclk_lvl) |=> state_q == SQ_DISCH);
endmodule

// File: rtl/nvw_array.sv
module nvw_array #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/nvbyte_wr_ctrl.sv
module nvbyte_wr_ctrl
  import nvw_pkg::*;
#(
  parameter int AW        = 4,
  parameter int EDGES     = 4,
  parameter int ERASE_CYC = 6,
  parameter int PROG_CYC  = 10,
  parameter int DISCH_CYC = 8,
  parameter int SYNC_LEN  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_ofs,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata
);
  localparam int DW = 8;

  logic          rstn_i;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;
  logic          msel_q, msel_d, csel_q, csel_d, wen_q, wen_d, err_q, err_d;
  logic          armed, busy, erase_we, prog_we;
  logic          wr_ctrl, try_start, go, rd_mem;
  logic          mem_we;
  logic [DW-1:0] mem_wdata, mem_rdata;

  nvw_rst_sync #(.STAGES(SYNC_LEN)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rstn_i));

  nvw_unlock u_key (
    .clk(clk), .rst_n(rstn_i), .acc_wr(bus_wr), .acc_rd(bus_rd),
    .acc_ofs(bus_ofs), .acc_data(bus_wdata), .armed(armed));

  nvw_seq #(.EDGES(EDGES), .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC),
            .DISCH_CYC(DISCH_CYC), .SYNC_LEN(SYNC_LEN)) u_seq (
    .clk(clk), .rst_n(rstn_i), .sclk(sclk), .go(go), .busy(busy),
    .erase_we(erase_we), .prog_we(prog_we));

  assign mem_we    = erase_we | prog_we;
  assign mem_wdata = erase_we ? {DW{1'b1}} : data_q;

  nvw_array #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .rst_n(rstn_i), .we(mem_we), .waddr(addr_q),
    .wdata(mem_wdata), .raddr(addr_q), .rdata(mem_rdata));

  assign wr_ctrl   = bus_wr && (bus_ofs == OFS_CTRL) && !busy;
  assign try_start = wr_ctrl && bus_wdata[B_START];
  assign go        = try_start && armed && wen_q &&
                     !bus_wdata[B_MSEL] && !bus_wdata[B_CSEL];
  assign rd_mem    = wr_ctrl && bus_wdata[B_RD] && !bus_wdata[B_START];

  always_comb begin
    addr_d = addr_q;
    data_d = data_q;
    msel_d = msel_q;
    csel_d = csel_q;
    wen_d  = wen_q;
    err_d  = err_q;
    if (bus_wr && !busy && bus_ofs == OFS_ADDR) addr_d = bus_wdata[AW-1:0];
    if (rd_mem)
      data_d = mem_rdata;
    else if (bus_wr && !busy && bus_ofs == OFS_DATA)
      data_d = bus_wdata;
    if (wr_ctrl) begin
      msel_d = bus_wdata[B_MSEL];
      csel_d = bus_wdata[B_CSEL];
      wen_d  = bus_wdata[B_WEN];
      err_d  = try_start ? !go : (err_q & bus_wdata[B_ERR]);
    end
  end

  always_ff @(posedge clk or negedge rstn_i) begin
    if (!rstn_i) begin
      addr_q <= '0;
      data_q <= '0;
      msel_q <= 1'b0;
      csel_q <= 1'b0;
      wen_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      addr_q <= addr_d;
      data_q <= data_d;
      msel_q <= msel_d;
      csel_q <= csel_d;
      wen_q  <= wen_d;
      err_q  <= err_d;
    end
  end

  always_comb begin
    case (bus_ofs)
      OFS_ADDR: bus_rdata = DW'(addr_q);
      OFS_DATA: bus_rdata = data_q;
      OFS_CTRL: bus_rdata = {msel_q, csel_q, 2'b00, err_q, wen_q, busy, 1'b0};
      default:  bus_rdata = '0;
    endcase
  end

  // R3: the sequencer only leaves idle after a keyed, enabled start write
  a_r3_start_needs_key: assert property (@(posedge clk) disable iff (!rstn_i)
    $rose(busy) |-> $past(armed && wen_q && bus_wr && bus_ofs == OFS_CTRL));
  // R10: operands are frozen while busy
  a_r10_operands_frozen: assert property (@(posedge clk) disable iff (!rstn_i)
    (busy && $past(busy)) |-> ($stable(addr_q) && $stable(data_q)));
  // R4: the store is only written during an accepted operation
  a_r4_store_only_busy: assert property (@(posedge clk) disable iff (!rstn_i)
    mem_we |-> busy);
  // R4: a start attempt while idle that is rejected raises the error flag
  a_r4_reject_flags: assert property (@(posedge clk) disable iff (!rstn_i)
    (try_start && !armed) |=> (err_q && !busy));
endmodule

// File: tb/nvbyte_wr_ctrl_test.sv
module nvbyte_wr_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int DISCH = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [1:0] bus_ofs = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;

  int errors = 0;
  int checks = 0;
  logic [7:0] model [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  nvbyte_wr_ctrl uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_ofs(bus_ofs), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] ofs, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_ofs = ofs; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] ofs, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_ofs = ofs;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic sclk_pulse();
    sclk = 1'b1;
    repeat (3) @(negedge clk);
    sclk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic read_store(input logic [3:0] a, output logic [7:0] d);
    bus_write(2'd0, {4'h0, a});
    bus_write(2'd2, 8'h05);
    bus_read(2'd1, d);
  endtask

  task automatic wait_done(output int polls);
    logic [7:0] c;
    polls = 0;
    c = 8'h02;
    while (c[1] && polls < 500) begin
      bus_read(2'd2, c);
      polls++;
    end
    chk(!c[1], "R8 start bit clears", c, 0);
  endtask

  function automatic logic accept_exp(input int kind);
    return kind == 0;
  endfunction

  // kinds: 0 valid, 1 missing AAh, 2 read between, 3 wren 0,
  //        4 bit7 set, 5 bit6 set, 6 keys swapped
  task automatic flow(input int kind, input logic [3:0] a, input logic [7:0] d);
    logic [7:0] c, r;
    int polls;
    bus_write(2'd0, {4'h0, a});
    bus_write(2'd1, d);
    bus_write(2'd2, (kind == 3) ? 8'h00 : 8'h04);
    if (kind == 6) begin
      bus_write(2'd3, 8'hAA); bus_write(2'd3, 8'h55);
    end else begin
      bus_write(2'd3, 8'h55);
      if (kind != 1) bus_write(2'd3, 8'hAA);
      if (kind == 2) bus_read(2'd0, r);
    end
    bus_write(2'd2, (kind == 4) ? 8'h86 : (kind == 5) ? 8'h46 : 8'h06);
    bus_read(2'd2, c);
    chk(c[1] == accept_exp(kind), "R3 start accepted", c[1], accept_exp(kind));
    chk(c[3] == !accept_exp(kind), "R4 error flag", c[3], !accept_exp(kind));
    if (accept_exp(kind)) begin
      repeat (4) sclk_pulse();
      wait_done(polls);
      model[a] = d;
    end
    read_store(a, r);
    chk(r == model[a], "R7 store content", r, model[a]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int polls;
    void'($urandom(32'd4242));
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset values
    bus_read(2'd2, r); chk(r == 8'h00, "R1 ctrl reset", r, 8'h00);
    bus_read(2'd0, r); chk(r == 8'h00, "R1 addr reset", r, 8'h00);
    bus_read(2'd1, r); chk(r == 8'h00, "R1 data reset", r, 8'h00);
    read_store(4'd5, r); chk(r == 8'hFF, "R1 store erased at reset", r, 8'hFF);
    // R11 read bit reads as 0
    bus_read(2'd2, r); chk(r[0] == 1'b0, "R11 read bit reads 0", r[0], 0);
    // R1 register readback
    bus_write(2'd0, 8'h0B); bus_read(2'd0, r); chk(r == 8'h0B, "R1 addr readback", r, 8'h0B);
    bus_write(2'd1, 8'h3C); bus_read(2'd1, r); chk(r == 8'h3C, "R1 data readback", r, 8'h3C);

    // R6 / R10 / R9 directed sequence
    bus_write(2'd0, 8'h03); bus_write(2'd1, 8'h5A); bus_write(2'd2, 8'h04);
    bus_write(2'd3, 8'h55); bus_write(2'd3, 8'hAA); bus_write(2'd2, 8'h06);
    repeat (3) sclk_pulse();
    repeat (50) @(negedge clk);
    bus_read(2'd2, r); chk(r[1], "R6 waits for fourth sclk fall", r[1], 1);
    bus_write(2'd0, 8'h09); bus_write(2'd1, 8'hC3); bus_write(2'd2, 8'h00);
    bus_read(2'd0, r); chk(r == 8'h03, "R10 addr write ignored while busy", r, 8'h03);
    bus_read(2'd1, r); chk(r == 8'h5A, "R10 data write ignored while busy", r, 8'h5A);
    bus_read(2'd2, r); chk(r[2], "R10 ctrl write ignored while busy", r[2], 1);
    sclk_pulse();
    sclk = 1'b1;
    repeat (100) @(negedge clk);
    bus_read(2'd2, r); chk(r[1], "R9 no completion while sclk high", r[1], 1);
    sclk = 1'b0;
    wait_done(polls);
    chk(polls >= DISCH - 4, "R9 discharge interval respected", polls, DISCH - 4);
    model[3] = 8'h5A;
    read_store(4'd3, r); chk(r == 8'h5A, "R7 programmed value", r, 8'h5A);
    read_store(4'd9, r); chk(r == 8'hFF, "R10 other byte untouched", r, 8'hFF);

    // R5 key consumed by a rejected attempt
    bus_write(2'd2, 8'h04);
    bus_write(2'd3, 8'h55); bus_write(2'd3, 8'hAA); bus_write(2'd2, 8'h46);
    bus_write(2'd2, 8'h06);
    bus_read(2'd2, r);
    chk(!r[1] && r[3], "R5 key consumed by prior attempt", r, 8'h0C);
    // R4 error cleared by writing 0 to bit 3
    bus_write(2'd2, 8'h04);
    bus_read(2'd2, r); chk(r == 8'h04, "R4 error cleared", r, 8'h04);
    // R2 key then write to another register breaks it
    bus_write(2'd3, 8'h55); bus_write(2'd3, 8'hAA); bus_write(2'd1, 8'h11);
    bus_write(2'd2, 8'h06);
    bus_read(2'd2, r); chk(!r[1] && r[3], "R2 intervening write breaks key", r, 8'h0C);

    // randomized flows covering R2 R3 R4 R5 R7
    for (int n = 0; n < 40; n++) begin
      int kind;
      kind = ($urandom % 2 == 0) ? 0 : int'($urandom % 7);
      flow(kind, 4'($urandom), 8'($urandom));
    end
    for (int i = 0; i < DEPTH; i++) begin
      read_store(4'(i), r);
      chk(r == model[i], "R7 final store sweep", r, model[i]);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule